// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor. Every cycle it looks at the pending, enable and 8-bit priority inputs for each interrupt source. It picks the most urgent source that beats the processor's priority threshold and raises an interrupt request line when it may signal. The processor takes an interrupt by issuing an acknowledge read. The read returns the chosen interrupt ID and marks that interrupt as in service. A pulse carrying the ID goes back to the distributor so that it can update its pending state. Clearing level or edge pending state is the distributor's job.

The processor finishes service by writing the same ID to the end-of-interrupt port. A matching write retires the interrupt and sends a completion pulse to the distributor. Any other end-of-interrupt write is dropped. A single in-service slot is kept: while an interrupt is in service, no new request is raised. When nothing can be granted, the acknowledge read returns the reserved spurious ID 1023.

A control register and a priority-threshold register complete the interface. Control bit 0 enables signalling to the processor. The upper control bits are bypass-disable flags. Each control write carries a bit mask, so the enable can be changed without disturbing the bypass bits.

The sequencing is a two-state machine. `ST_IDLE` means no interrupt is in service. `ST_SERVICE` means one interrupt is in service, and its ID is held in the slot. There are two transitions:
- **grant** moves from `ST_IDLE` to `ST_SERVICE` on an acknowledge read while enabled with a qualifying source.
- **retire** moves from `ST_SERVICE` to `ST_IDLE` on an end-of-interrupt write whose ID equals the held ID.

Top module: `irq_ack_port`

## Requirements
- R1: After reset `cpu_irq`, `ack_vld`, `dist_ack` and `dist_eoi` are 0, `ctrl_q` is 0 and `pmask_q` is 0, and the state is `ST_IDLE`.
- R2: Source index i has interrupt ID i. A source qualifies when its `src_pend` and `src_en` bits are 1 and its priority (bits [8i+7:8i] of `src_prio`) is numerically below `pmask_q`. The selected source is the qualifying one with the lowest priority value; on a tie the lowest ID wins.
- R3: An `ack_rd` pulse in `ST_IDLE`, with `ctrl_q[0]`=1 and a qualifying source, gives `ack_vld`=1 one cycle later with `ack_id` equal to the selected ID. In the same cycle `dist_ack` pulses, and the state becomes `ST_SERVICE`.
- R4: An `ack_rd` with no qualifying source, with `ctrl_q[0]`=0, or in `ST_SERVICE` returns `ack_id`=1023 one cycle later and leaves `dist_ack` at 0.
- R5: The threshold is strict: a source whose priority equals `pmask_q` does not qualify, and one with priority `pmask_q`-1 does.
- R6: `cpu_irq` is 1, combinationally, exactly when `ctrl_q[0]`=1, the state is `ST_IDLE` and a qualifying source exists.
- R7: An `eoi_wr` in `ST_SERVICE` with `eoi_id` equal to the in-service ID pulses `dist_eoi` one cycle later, with `dist_eoi_id` = that ID, and returns the state to `ST_IDLE`.
- R8: An `eoi_wr` whose ID differs from the in-service ID, or that arrives in `ST_IDLE`, is ignored: `dist_eoi` stays 0 and the state does not change.
- R9: A `ctrl_wr` updates only the `ctrl_q` bits whose `ctrl_wmask` bit is 1. Bit 0 is the enable; bits [3:1] are bypass-disable flags that keep their value when only bit 0 is written.
- R10: A `pmask_wr` loads `pmask_wdata` into `pmask_q` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NUM_IRQ | Pending flag per source, from the distributor |
| src_en | input | NUM_IRQ | Enable flag per source, from the distributor |
| src_prio | input | NUM_IRQ*PRIO_W | Priority per source, packed; lower value is more urgent |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wmask | input | CTRL_W | Per-bit write enable for the control write |
| ctrl_wdata | input | CTRL_W | Control write data |
| ctrl_q | output | CTRL_W | Control register: bit 0 enable, upper bits bypass-disable flags |
| pmask_wr | input | 1 | Priority threshold write strobe |
| pmask_wdata | input | PRIO_W | Priority threshold write data |
| pmask_q | output | PRIO_W | Priority threshold |
| cpu_irq | output | 1 | Interrupt request to the processor |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_vld | output | 1 | Acknowledge read data valid, one cycle after `ack_rd` |
| ack_id | output | 10 | Acknowledged ID, or 1023 when spurious |
| dist_ack | output | 1 | Acknowledge pulse to the distributor (ID on `ack_id`) |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | End-of-interrupt ID |
| dist_eoi | output | 1 | Completion pulse to the distributor |
| dist_eoi_id | output | 10 | ID that completed |

## Verification
Suppose the in-service slot holds the wrong ID, or the state is stuck in `ST_SERVICE`. Then `cpu_irq` stays low while sources qualify. On the next end-of-interrupt write, `dist_eoi` also fails to pulse. Both are visible within one cycle of that write. A fault in the selection scan shows as a wrong `ack_id` on the very next acknowledge, and seeded random priorities with frequent ties expose tie-break and threshold errors. A control write that disturbs the bypass flags shows on `ctrl_q` right after the write edge.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

    typedef enum logic {
        ST_IDLE,
        ST_SERVICE
    } svc_state_t;
endpackage

// File: rtl/irq_ack_select.sv
module irq_ack_select
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        en_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic                      found_o,
    output logic [ID_W-1:0]           win_id_o
);
    logic [PRIO_W-1:0] prio_arr [NUM_IRQ];
    logic [PRIO_W-1:0] best;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // The running best starts at the threshold, so a strict compare gives the
    // threshold rule and the lower-ID tie rule together.
    always_comb begin
        found_o  = 1'b0;
        best     = thresh_i;
        win_id_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend_i[i] && en_i[i] && (prio_arr[i] < best)) begin
                found_o  = 1'b1;
                best     = prio_arr[i];
                win_id_o = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_cfg.sv
module irq_ack_cfg #(
    parameter int CTRL_W = 4,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wmask,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              pmask_wr,
    input  logic [PRIO_W-1:0] pmask_wdata,
    output logic [PRIO_W-1:0] pmask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pmask_q <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= (ctrl_q & ~ctrl_wmask) | (ctrl_wdata & ctrl_wmask);
            if (pmask_wr)
                pmask_q <= pmask_wdata;
        end
    end

    // R9
    bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wmask[CTRL_W-1:1] == '0) |=> $stable(ctrl_q[CTRL_W-1:1]));

    // R10
    pmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmask_wr |=> (pmask_q == $past(pmask_wdata)));
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sig_en_i,
    input  logic            found_i,
    input  logic [ID_W-1:0] win_id_i,
    input  logic            ack_rd,
    input  logic            eoi_wr,
    input  logic [ID_W-1:0] eoi_id,
    output logic            idle_o,
    output logic            ack_vld,
    output logic [ID_W-1:0] ack_id,
    output logic            dist_ack,
    output logic            dist_eoi,
    output logic [ID_W-1:0] dist_eoi_id
);
    svc_state_t      state_q, state_d;
    logic [ID_W-1:0] act_id_q;
    logic            grant, retire;

    assign grant  = (state_q == ST_IDLE) && ack_rd && sig_en_i && found_i;
    assign retire = (state_q == ST_SERVICE) && eoi_wr && (eoi_id == act_id_q);
    assign idle_o = (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (grant)  state_d = ST_SERVICE;
            ST_SERVICE: if (retire) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            act_id_q <= SPUR_ID;
        end else begin
            state_q <= state_d;
            if (grant)
                act_id_q <= win_id_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld     <= 1'b0;
            ack_id      <= SPUR_ID;
            dist_ack    <= 1'b0;
            dist_eoi    <= 1'b0;
            dist_eoi_id <= SPUR_ID;
        end else begin
            ack_vld  <= ack_rd;
            dist_ack <= grant;
            dist_eoi <= retire;
            if (ack_rd)
                ack_id <= grant ? win_id_i : SPUR_ID;
            if (retire)
                dist_eoi_id <= act_id_q;
        end
    end

    // R3
    ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_ack |-> ($past(ack_rd) && ack_vld));

    // R4
    spur_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_id == SPUR_ID) |-> !dist_ack);

    // R7
    eoi_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_eoi |-> ($past(eoi_wr) && dist_eoi_id == $past(eoi_id)));

    // R8
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dist_ack, dist_eoi}));
endmodule

// File: rtl/irq_ack_port.sv
module irq_ack_port
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8,
    parameter int CTRL_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        src_pend,
    input  logic [NUM_IRQ-1:0]        src_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] src_prio,
    input  logic                      ctrl_wr,
    input  logic [CTRL_W-1:0]         ctrl_wmask,
    input  logic [CTRL_W-1:0]         ctrl_wdata,
    output logic [CTRL_W-1:0]         ctrl_q,
    input  logic                      pmask_wr,
    input  logic [PRIO_W-1:0]         pmask_wdata,
    output logic [PRIO_W-1:0]         pmask_q,
    output logic                      cpu_irq,
    input  logic                      ack_rd,
    output logic                      ack_vld,
    output logic [ID_W-1:0]           ack_id,
    output logic                      dist_ack,
    input  logic                      eoi_wr,
    input  logic [ID_W-1:0]           eoi_id,
    output logic                      dist_eoi,
    output logic [ID_W-1:0]           dist_eoi_id
);
    logic            found;
    logic [ID_W-1:0] win_id;
    logic            idle;

    irq_ack_cfg #(.CTRL_W(CTRL_W), .PRIO_W(PRIO_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wmask(ctrl_wmask), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q),
        .pmask_wr(pmask_wr), .pmask_wdata(pmask_wdata), .pmask_q(pmask_q)
    );

    irq_ack_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) sel_i (
        .pend_i(src_pend), .en_i(src_en), .prio_i(src_prio),
        .thresh_i(pmask_q), .found_o(found), .win_id_o(win_id)
    );

    irq_ack_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .sig_en_i(ctrl_q[0]), .found_i(found), .win_id_i(win_id),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr), .eoi_id(eoi_id),
        .idle_o(idle),
        .ack_vld(ack_vld), .ack_id(ack_id), .dist_ack(dist_ack),
        .dist_eoi(dist_eoi), .dist_eoi_id(dist_eoi_id)
    );

    assign cpu_irq = ctrl_q[0] && idle && found;

    // R6
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ctrl_q[0]);

    // R6
    irq_quiet_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_ack |-> !cpu_irq);
endmodule

// File: tb/irq_ack_port_tb.sv
module irq_ack_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int SPUR = 1023;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   src_pend = '0, src_en = '0;
    logic [N*8-1:0] src_prio = '0;
    logic           ctrl_wr = 1'b0, pmask_wr = 1'b0, ack_rd = 1'b0, eoi_wr = 1'b0;
    logic [3:0]     ctrl_wmask = '0, ctrl_wdata = '0, ctrl_q;
    logic [7:0]     pmask_wdata = '0, pmask_q;
    logic [9:0]     eoi_id = '0, ack_id, dist_eoi_id;
    logic           cpu_irq, ack_vld, dist_ack, dist_eoi;

    logic [7:0] pr [N];
    int tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ack_port dut_i (
        .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
        .src_prio(src_prio), .ctrl_wr(ctrl_wr), .ctrl_wmask(ctrl_wmask),
        .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .pmask_wr(pmask_wr),
        .pmask_wdata(pmask_wdata), .pmask_q(pmask_q), .cpu_irq(cpu_irq),
        .ack_rd(ack_rd), .ack_vld(ack_vld), .ack_id(ack_id), .dist_ack(dist_ack),
        .eoi_wr(eoi_wr), .eoi_id(eoi_id), .dist_eoi(dist_eoi),
        .dist_eoi_id(dist_eoi_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference pick: minimum priority first, then lowest ID holding it.
    function automatic int ref_pick(input logic [N-1:0] p, input logic [N-1:0] e,
                                    input logic [7:0] m);
        int mn = 256;
        for (int i = 0; i < N; i++)
            if (p[i] && e[i] && pr[i] < m && int'(pr[i]) < mn) mn = int'(pr[i]);
        if (mn == 256) return SPUR;
        for (int i = 0; i < N; i++)
            if (p[i] && e[i] && int'(pr[i]) == mn) return i;
        return SPUR;
    endfunction

    task automatic set_src(input logic [N-1:0] p, input logic [N-1:0] e);
        @(negedge clk);
        src_pend = p;
        src_en = e;
        for (int i = 0; i < N; i++) src_prio[i*8 +: 8] = pr[i];
        #1;
    endtask

    task automatic wr_ctrl(input logic [3:0] m, input logic [3:0] d);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wmask = m; ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_pmask(input logic [7:0] d);
        @(negedge clk);
        pmask_wr = 1'b1; pmask_wdata = d;
        @(negedge clk);
        pmask_wr = 1'b0;
    endtask

    task automatic do_ack(output int id, output bit vld, output bit dack);
        @(negedge clk);
        ack_rd = 1'b1;
        @(negedge clk);
        ack_rd = 1'b0;
        id = int'(ack_id); vld = ack_vld; dack = dist_ack;
    endtask

    task automatic do_eoi(input int id, output bit de, output int did);
        @(negedge clk);
        eoi_wr = 1'b1; eoi_id = 10'(id);
        @(negedge clk);
        eoi_wr = 1'b0;
        de = dist_eoi; did = int'(dist_eoi_id);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int id, did, exp;
        bit vld, dack, de;
        logic [N-1:0] p, e;
        logic [7:0] m;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) pr[i] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cpu_irq == 0 && ack_vld == 0 && dist_ack == 0 && dist_eoi == 0, "R1 outputs", int'(cpu_irq), 0);
        chk(ctrl_q == 0 && pmask_q == 0, "R1 registers", int'(ctrl_q), 0);

        // R10 threshold load
        wr_pmask(8'hFF);
        chk(pmask_q == 8'hFF, "R10 pmask", int'(pmask_q), 255);

        // Disabled interface: R6 no request, R4 spurious
        pr[3] = 8'h10;
        set_src(32'h8, 32'h8);
        chk(cpu_irq == 0, "R6 disabled irq", int'(cpu_irq), 0);
        do_ack(id, vld, dack);
        chk(vld && id == SPUR, "R4 disabled ack", id, SPUR);
        chk(dack == 0, "R4 disabled no dist_ack", int'(dack), 0);

        // R9 masked control writes
        wr_ctrl(4'b1110, 4'b1010);
        chk(ctrl_q == 4'b1010, "R9 bypass write", int'(ctrl_q), 10);
        wr_ctrl(4'b0001, 4'b1111);
        chk(ctrl_q == 4'b1011, "R9 enable keeps bypass", int'(ctrl_q), 11);

        // R2 tie break: IDs 17 and 20 at 0x40, 25 at 0x80
        for (int i = 0; i < N; i++) pr[i] = 8'hF0;
        pr[17] = 8'h40; pr[20] = 8'h40; pr[25] = 8'h80;
        set_src(32'h0212_0000, 32'hFFFF_FFFF);
        chk(cpu_irq == 1, "R6 irq raised", int'(cpu_irq), 1);
        do_ack(id, vld, dack);
        chk(vld && id == 17, "R2 tie lowest id", id, 17);
        chk(dack == 1, "R3 dist_ack pulse", int'(dack), 1);
        #1;
        chk(cpu_irq == 0, "R6 quiet in service", int'(cpu_irq), 0);
        do_ack(id, vld, dack);
        chk(id == SPUR && dack == 0, "R4 ack in service", id, SPUR);
        do_eoi(20, de, did);
        chk(de == 0, "R8 mismatched eoi", int'(de), 0);
        #1;
        chk(cpu_irq == 0, "R8 still in service", int'(cpu_irq), 0);
        do_eoi(17, de, did);
        chk(de == 1 && did == 17, "R7 matching eoi", did, 17);
        #1;
        chk(cpu_irq == 1, "R7 back to idle", int'(cpu_irq), 1);

        // R5 strict threshold
        wr_pmask(8'h40);
        chk(cpu_irq == 0, "R5 equal masked", int'(cpu_irq), 0);
        do_ack(id, vld, dack);
        chk(id == SPUR, "R5 equal spurious", id, SPUR);
        wr_pmask(8'h41);
        chk(cpu_irq == 1, "R5 below passes", int'(cpu_irq), 1);
        do_ack(id, vld, dack);
        chk(id == 17, "R5 ack below", id, 17);
        do_eoi(17, de, did);
        chk(de == 1, "R7 eoi after R5", int'(de), 1);

        // R8 eoi while idle
        do_eoi(5, de, did);
        chk(de == 0, "R8 idle eoi", int'(de), 0);

        // Random patterns against the reference pick
        for (int it = 0; it < 300; it++) begin
            p = $urandom;
            e = $urandom;
            m = 8'($urandom_range(0, 255));
            for (int i = 0; i < N; i++) pr[i] = 8'($urandom_range(0, 15) * 16);
            wr_pmask(m);
            set_src(p, e);
            exp = ref_pick(p, e, m);
            chk(cpu_irq == (exp != SPUR), "R6 random irq", int'(cpu_irq), int'(exp != SPUR));
            do_ack(id, vld, dack);
            chk(vld && id == exp, "R2 random pick", id, exp);
            chk(dack == (exp != SPUR), "R3 random dist_ack", int'(dack), int'(exp != SPUR));
            if (exp != SPUR) begin
                do_eoi(exp, de, did);
                chk(de == 1 && did == exp, "R7 random eoi", did, exp);
            end
        end

        // R6 disable with a qualifier present, R9 bypass bits kept
        for (int i = 0; i < N; i++) pr[i] = 8'h20;
        wr_pmask(8'hFF);
        set_src(32'h1, 32'h1);
        wr_ctrl(4'b0001, 4'b0000);
        #1;
        chk(cpu_irq == 0, "R6 disabled with qualifier", int'(cpu_irq), 0);
        chk(ctrl_q == 4'b1010, "R9 disable keeps bypass", int'(ctrl_q), 10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule